// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 channel from a cold reset to the point where normal traffic may begin. After a start pulse it keeps the memory reset line low, then releases it, then waits again before it raises clock enable. After a short settle time it sends mode-register writes to the populated chip selects, sends two long ZQ calibration commands, and raises a sticky done flag.

Every command goes out as a one-cycle strobe that carries address, bank and chip select toward the PHY. The sequencer then holds until the PHY returns an acknowledge. All four mode-register payloads are computed elsewhere and arrive as inputs. The sequencer only adds the DLL-reset bit, picks the order of the writes, and swaps address and bank bits on mirrored unbuffered ranks. All delays are counted in controller clocks. They are derived from the clock period parameter, and a speed divisor can shorten them for simulation.

Top module: `ddr3_init_seq`

## Requirements
- R1: While reset is applied and after its release, mem_reset_n, cke, cmd_valid, busy and init_done are all 0.
- R2: After a start pulse, mem_reset_n stays low for ceil(200 us / (CLK_PERIOD_PS x SIM_DIV)) clock cycles and then goes high.
- R3: Once mem_reset_n is high, cke rises after ceil(500 us / (CLK_PERIOD_PS x SIM_DIV)) cycles. After that it stays high and is never high while mem_reset_n is low.
- R4: The first command strobe comes ceil(360 ns / (CLK_PERIOD_PS x SIM_DIV)) cycles after cke rises and never while cke is low.
- R5: For each rank it visits, the sequencer writes mode registers 2, 3, 1 and 0, in that order. A mode-register command has cmd_mrs=1 and cmd_bank={0, MR index}, so MR0=000, MR1=001, MR2=010 and MR3=011. Its cmd_addr equals the matching payload input.
- R6: A MR0 write always carries cmd_addr bit 8 set (DLL reset), even when the payload has it clear.
- R7: With registered=1, every chip select whose cs_present bit is set gets the full group, in ascending chip-select order. Absent chip selects are skipped.
- R8: With registered=0, only the lowest present chip select gets the group. The other present chip selects receive no mode-register write.
- R9: On an unbuffered rank whose mirror_mask bit is set, address bits 3/4, 5/6 and 7/8 are exchanged, and bank bits 0/1 are exchanged. No other bit changes. With registered=1, mirror_mask has no effect.
- R10: cmd_valid is high for exactly one cycle per command. No new strobe is issued until cmd_ack has been seen for the previous one.
- R11: After the mode-register writes come two ZQ long calibration commands. Each has cmd_mrs=0, cmd_addr with only bit 10 set, cmd_bank=0 and cmd_cs=0.
- R12: After the acknowledge of each ZQ command, the sequencer waits ceil(ZQ_MCLKS / (MCLK_PER_CLK x SIM_DIV)) cycles. After the second wait, init_done rises and stays high, and busy falls.
- R13: A start pulse while busy, or after init_done, has no effect. The command stream, mem_reset_n, cke and init_done are unchanged.
- R14: With no chip select present, no mode-register write is sent and the two ZQ commands follow the clock-enable settle time directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins the sequence |
| cs_present | input | NUM_CS | Populated chip-select mask |
| registered | input | 1 | 1 for registered DIMMs, 0 for unbuffered |
| mirror_mask | input | NUM_CS | Chip selects wired with mirrored address/bank lines |
| mr0_val | input | ADDR_W | Mode register 0 payload |
| mr1_val | input | ADDR_W | Mode register 1 payload |
| mr2_val | input | ADDR_W | Mode register 2 payload |
| mr3_val | input | ADDR_W | Mode register 3 payload |
| cmd_ack | input | 1 | PHY acknowledge of the pending command |
| mem_reset_n | output | 1 | Memory reset line, active low |
| cke | output | 1 | Memory clock enable |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_mrs | output | 1 | 1 for mode-register write, 0 for ZQ long calibration |
| cmd_addr | output | ADDR_W | Command address |
| cmd_bank | output | BANK_W | Command bank address |
| cmd_cs | output | CS_W | Command chip select |
| busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Sticky completion flag |

## Verification
Two events can land in the same cycle: a fresh start pulse, and the PHY acknowledge that moves the sequencer to its next command. The bench provokes this by raising start in the same cycle as the sixth acknowledge of a registered run. A scoreboard then compares the command stream after that point against the expected list. The bench also confirms that mem_reset_n and cke never drop and that init_done arrives on time.

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq #(
  parameter int CLK_PERIOD_PS = 2500,
  parameter int SIM_DIV       = 1,
  parameter int NUM_CS        = 8,
  parameter int ADDR_W        = 16,
  parameter int BANK_W        = 3,
  parameter int ZQ_MCLKS      = 512,
  parameter int MCLK_PER_CLK  = 1,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_CS-1:0] cs_present,
  input  logic              registered,
  input  logic [NUM_CS-1:0] mirror_mask,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] mr1_val,
  input  logic [ADDR_W-1:0] mr2_val,
  input  logic [ADDR_W-1:0] mr3_val,
  input  logic              cmd_ack,
  output logic              mem_reset_n,
  output logic              cke,
  output logic              cmd_valid,
  output logic              cmd_mrs,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [CS_W-1:0]   cmd_cs,
  output logic              busy,
  output logic              init_done
);
  localparam longint STEP_PS = longint'(CLK_PERIOD_PS) * SIM_DIV;
  localparam longint ZQ_STEP = longint'(MCLK_PER_CLK) * SIM_DIV;
  localparam int T_RST  = int'((64'd200_000_000 + STEP_PS - 1) / STEP_PS);
  localparam int T_STAB = int'((64'd500_000_000 + STEP_PS - 1) / STEP_PS);
  localparam int T_TXPR = int'((64'd360_000 + STEP_PS - 1) / STEP_PS);
  localparam int T_ZQ   = int'((longint'(ZQ_MCLKS) + ZQ_STEP - 1) / ZQ_STEP);
  localparam int T_A    = (T_RST > T_STAB) ? T_RST : T_STAB;
  localparam int T_B    = (T_TXPR > T_ZQ) ? T_TXPR : T_ZQ;
  localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_STAB, S_TXPR, S_CMD, S_ACK, S_ZQW, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CS_W-1:0]  cs_idx;
  logic [1:0]       pos;
  logic             is_zq, zq_two, rstn_q, cke_q, done_q;

  logic [CS_W-1:0]   first_cs, next_cs;
  logic              first_ok, next_ok;
  logic [1:0]        mr_num;
  logic [ADDR_W-1:0] raw, mrs_addr;
  logic [BANK_W-1:0] raw_bank, mrs_bank;
  logic              mirrored;

  always_comb begin
    first_ok = 1'b0;
    first_cs = '0;
    next_ok  = 1'b0;
    next_cs  = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (cs_present[i]) begin
        first_ok = 1'b1;
        first_cs = CS_W'(i);
      end
      if (cs_present[i] && i > int'(cs_idx)) begin
        next_ok = 1'b1;
        next_cs = CS_W'(i);
      end
    end
  end

  always_comb begin
    case (pos)
      2'd0:    mr_num = 2'd2;
      2'd1:    mr_num = 2'd3;
      2'd2:    mr_num = 2'd1;
      default: mr_num = 2'd0;
    endcase
    case (mr_num)
      2'd0:    raw = mr0_val | (ADDR_W'(1) << 8);
      2'd1:    raw = mr1_val;
      2'd2:    raw = mr2_val;
      default: raw = mr3_val;
    endcase
  end

  assign raw_bank = BANK_W'(mr_num);
  assign mirrored = !registered && mirror_mask[cs_idx];

  always_comb begin
    mrs_addr = raw;
    mrs_bank = raw_bank;
    if (mirrored) begin
      mrs_addr[3] = raw[4];
      mrs_addr[4] = raw[3];
      mrs_addr[5] = raw[6];
      mrs_addr[6] = raw[5];
      mrs_addr[7] = raw[8];
      mrs_addr[8] = raw[7];
      mrs_bank[0] = raw_bank[1];
      mrs_bank[1] = raw_bank[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      cs_idx <= '0;
      pos    <= '0;
      is_zq  <= 1'b0;
      zq_two <= 1'b0;
      rstn_q <= 1'b0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            st  <= S_RST;
            cnt <= CNT_W'(T_RST - 1);
          end
        S_RST:
          if (cnt == '0) begin
            st     <= S_STAB;
            rstn_q <= 1'b1;
            cnt    <= CNT_W'(T_STAB - 1);
          end else cnt <= cnt - 1'b1;
        S_STAB:
          if (cnt == '0) begin
            st    <= S_TXPR;
            cke_q <= 1'b1;
            cnt   <= CNT_W'(T_TXPR - 1);
          end else cnt <= cnt - 1'b1;
        S_TXPR:
          if (cnt == '0) begin
            st     <= S_CMD;
            pos    <= 2'd0;
            cs_idx <= first_cs;
            is_zq  <= !first_ok;
          end else cnt <= cnt - 1'b1;
        S_CMD:
          st <= S_ACK;
        S_ACK:
          if (cmd_ack) begin
            if (is_zq) begin
              st  <= S_ZQW;
              cnt <= CNT_W'(T_ZQ - 1);
            end else if (pos != 2'd3) begin
              pos <= pos + 2'd1;
              st  <= S_CMD;
            end else begin
              pos <= 2'd0;
              st  <= S_CMD;
              if (registered && next_ok) cs_idx <= next_cs;
              else is_zq <= 1'b1;
            end
          end
        S_ZQW:
          if (cnt == '0) begin
            if (zq_two) begin
              st     <= S_DONE;
              done_q <= 1'b1;
            end else begin
              zq_two <= 1'b1;
              st     <= S_CMD;
            end
          end else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign mem_reset_n = rstn_q;
  assign cke         = cke_q;
  assign init_done   = done_q;
  assign busy        = (st != S_IDLE) && (st != S_DONE);
  assign cmd_valid   = (st == S_CMD);
  assign cmd_mrs     = !is_zq;
  assign cmd_addr    = is_zq ? (ADDR_W'(1) << 10) : mrs_addr;
  assign cmd_bank    = is_zq ? '0 : mrs_bank;
  assign cmd_cs      = is_zq ? '0 : cs_idx;
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              registered,
  input logic [NUM_CS-1:0] mirror_mask,
  input logic              mem_reset_n,
  input logic              cke,
  input logic              cmd_valid,
  input logic              cmd_mrs,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [CS_W-1:0]   cmd_cs,
  input logic              busy,
  input logic              init_done
);
  a_r3_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  a_r3_cke_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> mem_reset_n);
  a_r4_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cke);
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r11_zq_format: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_mrs) |-> (cmd_addr == (ADDR_W'(1) << 10)) && (cmd_bank == '0) && (cmd_cs == '0));
  a_r6_dll_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mrs && cmd_bank == '0) |->
      ((!registered && mirror_mask[cmd_cs]) ? cmd_addr[7] : cmd_addr[8]));
  a_r5_bank_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mrs) |-> (cmd_bank[BANK_W-1:2] == '0));
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!busy && !cmd_valid));
endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_chk (.*);

// File: tb/test_ddr3_init_seq.sv
`timescale 1ns/1ps
module test_ddr3_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_PS  = 2500;
  localparam int DIV        = 100;
  localparam int E_RST  = (200_000_000 + PERIOD_PS*DIV - 1) / (PERIOD_PS*DIV);
  localparam int E_STAB = (500_000_000 + PERIOD_PS*DIV - 1) / (PERIOD_PS*DIV);
  localparam int E_TXPR = (360_000 + PERIOD_PS*DIV - 1) / (PERIOD_PS*DIV);
  localparam int E_ZQ   = (512 + DIV - 1) / DIV;
  localparam logic [15:0] P0 = 16'h0A52, P1 = 16'h0046, P2 = 16'h0028, P3 = 16'h0004;

  typedef struct packed {
    logic        mrs;
    logic [2:0]  cs;
    logic [2:0]  bank;
    logic [15:0] addr;
  } item_t;

  logic clk = 0, rst_n = 0, start_a = 0, start_b = 0, cmd_ack = 0, registered = 0;
  logic [7:0] cs_present = 0, mirror_mask = 0;
  logic mem_reset_n, cke, cmd_valid, cmd_mrs, busy, init_done;
  logic [15:0] cmd_addr;
  logic [2:0] cmd_bank, cmd_cs;
  wire start = start_a | start_b;

  item_t q[$];
  string qt[$];
  int checks = 0, fails = 0, inject_at = 0, ack_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr3_init_seq #(.CLK_PERIOD_PS(PERIOD_PS), .SIM_DIV(DIV)) i_ddr3_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_present(cs_present),
    .registered(registered), .mirror_mask(mirror_mask),
    .mr0_val(P0), .mr1_val(P1), .mr2_val(P2), .mr3_val(P3), .cmd_ack(cmd_ack),
    .mem_reset_n(mem_reset_n), .cke(cke), .cmd_valid(cmd_valid), .cmd_mrs(cmd_mrs),
    .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_cs(cmd_cs),
    .busy(busy), .init_done(init_done));

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic item_t mir(input item_t e);
    item_t r = e;
    r.addr[3] = e.addr[4]; r.addr[4] = e.addr[3];
    r.addr[5] = e.addr[6]; r.addr[6] = e.addr[5];
    r.addr[7] = e.addr[8]; r.addr[8] = e.addr[7];
    r.bank[0] = e.bank[1]; r.bank[1] = e.bank[0];
    return r;
  endfunction

  task automatic push_rank(input int cs, input bit m, input string base);
    for (int k = 0; k < 4; k++) begin
      int mr;
      item_t e;
      mr = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 1 : 0;
      e.mrs  = 1'b1;
      e.cs   = 3'(cs);
      e.bank = {1'b0, 2'(mr)};
      e.addr = (mr == 2) ? P2 : (mr == 3) ? P3 : (mr == 1) ? P1 : (P0 | 16'h0100);
      if (m) e = mir(e);
      q.push_back(e);
      qt.push_back((mr == 0) ? "R6" : base);
    end
  endtask

  task automatic push_zq();
    for (int k = 0; k < 2; k++) begin
      item_t e;
      e.mrs = 1'b0; e.cs = 3'd0; e.bank = 3'd0; e.addr = 16'h0400;
      q.push_back(e);
      qt.push_back("R11");
    end
  endtask

  // monitor: pops the scoreboard, tracks handshake and ZQ wait
  initial begin
    bit pend = 0, last_zq = 0, gap_on = 0;
    int gap = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin pend = 0; gap_on = 0; end
      else begin
        if (gap_on) begin
          gap++;
          if (cmd_valid || init_done) begin
            check(gap >= E_ZQ && gap <= E_ZQ + 1, "R12", "ZQ wait cycles", gap, E_ZQ);
            gap_on = 0;
          end
        end
        if (cmd_valid) begin
          item_t g;
          g = {cmd_mrs, cmd_cs, cmd_bank, cmd_addr};
          check(!pend, "R10", "strobe before acknowledge", 1, 0);
          pend = 1;
          last_zq = !cmd_mrs;
          if (q.size() == 0) check(0, "R13", "unexpected command", longint'(g), 0);
          else begin
            item_t e;
            string t;
            e = q.pop_front();
            t = qt.pop_front();
            check(g == e, t, "command", longint'(g), longint'(e));
          end
        end
        if (cmd_ack) begin
          pend = 0;
          if (last_zq) begin gap_on = 1; gap = 0; end
        end
      end
    end
  end

  // PHY model: acknowledges each strobe after 1 to 3 cycles
  initial begin
    int dly = 1;
    forever begin
      @(negedge clk);
      if (cmd_valid && rst_n) begin
        repeat (dly) @(posedge clk);
        #2 cmd_ack = 1;
        ack_cnt++;
        if (inject_at != 0 && ack_cnt == inject_at) start_b = 1;
        @(posedge clk);
        #2 cmd_ack = 0;
        start_b = 0;
        dly = dly % 3 + 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic do_reset(input logic [7:0] mask, input bit rmode, input logic [7:0] mm);
    @(posedge clk); #2 rst_n = 0;
    cs_present = mask; registered = rmode; mirror_mask = mm;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(!mem_reset_n && !cke && !cmd_valid && !busy && !init_done, "R1", "idle outputs",
          {mem_reset_n, cke, cmd_valid, busy, init_done}, 0);
  endtask

  task automatic run(input logic [7:0] mask, input bit rmode, input logic [7:0] mm,
                     input int inj, input string base, input string endtag);
    int n, w;
    bit found;
    do_reset(mask, rmode, mm);
    found = 0;
    for (int i = 0; i < 8; i++)
      if (mask[i] && (rmode || !found)) begin
        push_rank(i, !rmode && mm[i], found ? endtag : base);
        found = 1;
      end
    push_zq();
    inject_at = inj;
    ack_cnt = 0;
    @(posedge clk); #2 start_a = 1;
    @(posedge clk); #2 start_a = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!mem_reset_n);
    check(n - 1 >= E_RST && n - 1 <= E_RST + 1, "R2", "reset hold cycles", n - 1, E_RST);
    n = 0;
    do begin @(negedge clk); n++; end while (!cke);
    check(n >= E_STAB && n <= E_STAB + 1, "R3", "reset-to-cke cycles", n, E_STAB);
    n = 0;
    do begin @(negedge clk); n++; end while (!cmd_valid);
    check(n >= E_TXPR && n <= E_TXPR + 1, "R4", "cke-to-command cycles", n, E_TXPR);
    w = 0;
    while (!init_done && w < 20000) begin @(negedge clk); w++; end
    check(init_done, "R12", "init_done", init_done, 1);
    check(!busy, "R12", "busy after done", busy, 0);
    check(q.size() == 0, endtag, "commands left unsent", q.size(), 0);
    check(mem_reset_n && cke, inj != 0 ? "R13" : "R3", "reset/cke held", {mem_reset_n, cke}, 3);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // R5, R7, R13 (start coincides with 6th acknowledge), mirror ignored when registered (R9)
    run(8'b1010_0110, 1'b1, 8'hFF, 6, "R5", "R7");
    // R13: start after done
    @(posedge clk); #2 start_a = 1;
    @(posedge clk); #2 start_a = 0;
    repeat (30) @(negedge clk);
    check(mem_reset_n && cke && init_done && !busy, "R13", "state after late start",
          {mem_reset_n, cke, init_done, busy}, 4'b1110);
    // R8 + R9: unbuffered, first present rank mirrored
    run(8'b0110_1000, 1'b0, 8'b0000_1000, 0, "R9", "R8");
    // R8: unbuffered, first present rank not mirrored
    run(8'b1000_0100, 1'b0, 8'b1111_1011, 0, "R8", "R8");
    // R14: no rank present
    run(8'b0000_0000, 1'b1, 8'h00, 0, "R14", "R14");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule